// File: doc/BRIEF.md
# Soft-Decision Viterbi Decoder with Byte Output

This block decodes a rate-1/2 convolutional code with constraint length 3, a 4-state trellis. For each trellis step it takes two soft code symbols and a valid strobe. Each symbol is 3 bits in sign-magnitude form: a sign bit that gives the likely coded bit, and a 2-bit confidence. A register stage captures the inputs. The block then forms branch metrics from the symbol distances and runs add-compare-select across the four states. It keeps one decision bit per state and per step, and traces back from the best state over a depth chosen at run time. The decoded bits are gathered into bytes for a downstream deinterleaver.

Decoding always starts in state 0, as the encoder does. Cycles without a valid strobe do not change the decoder. The first bit that leaves the decoder belongs to the first valid step. After every eight decoded bits the block emits one byte.

Top module: `vit_soft_decoder`

## Requirements
- R1: The code uses generators 7 and 5 (octal). `in_sym_a` carries the generator-7 bit and `in_sym_b` the generator-5 bit. The trellis starts in state 0 after reset. A clean encoded stream decodes back to the original bits.
- R2: Symbol bit 2 is the sign: 0 means the coded bit is likely 0, and 1 means it is likely 1. Bits 1:0 give the confidence, where 3 is the strongest. A stream whose signs are all correct decodes without error at any mix of magnitudes.
- R3: Isolated full-confidence symbol errors, spaced well apart, are corrected when the traceback depth is 32.
- R4: Sparse zero-confidence symbols with the wrong sign do not disturb the decoded data.
- R5: The traceback depth is taken from `tb_len` and clamped to the range 8 to 32. A value below 8 acts as 8, and a value above 32 acts as 32.
- R6: `tb_len` is sampled only while `rst` is high. A change after reset has no effect until the next reset.
- R7: With depth D, the bit of valid step k leaves the decoder once step k+D has been received. After N valid steps, exactly floor((N-D)/8) bytes have been produced. The first byte appears on the (D+8)-th valid step.
- R8: Cycles with `in_valid` low are ignored, whatever value the symbol inputs hold.
- R9: Bytes are packed MSB first, so the earliest decoded bit lands in bit 7. Each byte is marked by a one-cycle `out_valid` pulse.
- R10: The 8-bit path metrics are rebased by their minimum whenever any of them reaches the upper half. Streams of hundreds of steps decode without the metrics wrapping.
- R11: During and after reset, `out_valid` and `out_byte` are 0. A reset in the middle of a stream discards all trellis and packing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the traceback depth |
| in_valid | input | 1 | Marks one trellis step on the symbol inputs |
| in_sym_a | input | 3 | Soft symbol for the generator-7 output, sign-magnitude |
| in_sym_b | input | 3 | Soft symbol for the generator-5 output, sign-magnitude |
| tb_len | input | 6 | Requested traceback depth in steps, sampled during reset |
| out_valid | output | 1 | One-cycle pulse marking a decoded byte |
| out_byte | output | 8 | Decoded byte, earliest bit in bit 7 |

## Verification
The metric-bound assertions rely on three things. Each branch metric is at most 14. The symbols are driven for a single cycle per valid step. The decoder holds the depth clamped to 8 to 32 after reset. The bench meets these limits by driving only 3-bit symbols, changing `tb_len` only in the tests that check it is ignored, and spacing injected errors more than the code's free distance apart. The bench places no error within 40 steps of the stream end, so the best-state start of traceback always lies on the correct path.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int MAG_W    = 2;
  localparam int SYM_W    = MAG_W + 1;
  localparam int NSTATE   = 4;
  localparam int ST_W     = $clog2(NSTATE);
  localparam int LEVELS   = 1 << MAG_W;
  localparam int DIST_MAX = 2 * LEVELS - 1;
  localparam int BM_W     = $clog2(2 * DIST_MAX + 1);

  typedef logic [SYM_W-1:0] soft_t;
  typedef logic [BM_W-1:0]  bm_t;
  typedef logic [ST_W-1:0]  state_t;

  // Map sign-magnitude onto a ladder 0..DIST_MAX (0 = certain zero),
  // then measure distance to the expected coded bit.
  function automatic bm_t sym_dist(soft_t s, logic e);
    bm_t lvl;
    if (s[SYM_W-1]) lvl = BM_W'(LEVELS) + BM_W'(s[MAG_W-1:0]);
    else            lvl = BM_W'(LEVELS - 1) - BM_W'(s[MAG_W-1:0]);
    return e ? (BM_W'(DIST_MAX) - lvl) : lvl;
  endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
  import vit_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  soft_t                 sym_a,
  input  soft_t                 sym_b,
  output bm_t [NSTATE-1:0]      bm
);
  // bm[c] is the cost of code pair {c0,c1} = c, c0 on sym_a.
  for (genvar c = 0; c < NSTATE; c++) begin : g_pair
    localparam logic [1:0] CODE = 2'(c);
    assign bm[c] = sym_dist(sym_a, CODE[1]) + sym_dist(sym_b, CODE[0]);
  end

  // R2: complementary code pairs always split the full distance budget
  for (genvar c = 0; c < NSTATE / 2; c++) begin : g_chk
    a_r2_bm_complement: assert property (@(posedge clk) disable iff (rst)
      (32'(bm[c]) + 32'(bm[NSTATE-1-c])) == 2 * DIST_MAX);
  end
endmodule

// File: rtl/vit_acs.sv
module vit_acs
  import vit_pkg::*;
#(
  parameter int PM_W    = 8,
  parameter int PM_INIT = 64
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step_en,
  input  bm_t [NSTATE-1:0]            bm,
  output logic [NSTATE-1:0][PM_W-1:0] pm,
  output logic [NSTATE-1:0]           dec
);
  localparam logic [PM_W-1:0] INIT_V = PM_W'(PM_INIT);
  localparam int GUARD = 3 << (PM_W - 2);

  logic                        norm;
  logic [PM_W-1:0]             pm_min;
  logic [NSTATE-1:0][PM_W-1:0] pm_adj;
  logic [NSTATE-1:0][PM_W-1:0] pm_nx;

  always_comb begin
    pm_min = pm[0];
    norm   = 1'b0;
    for (int i = 0; i < NSTATE; i++) begin
      if (pm[i] < pm_min) pm_min = pm[i];
      norm = norm | pm[i][PM_W-1];
    end
    for (int i = 0; i < NSTATE; i++)
      pm_adj[i] = norm ? (pm[i] - pm_min) : pm[i];
  end

  // State = {newest bit, previous bit}; next state {u, s[1]}.
  // Predecessors of ns are {ns[0],0} and {ns[0],1}; decision = that low bit.
  for (genvar ns = 0; ns < NSTATE; ns++) begin : g_acs
    localparam int U  = (ns >> 1) & 1;
    localparam int P1 = ns & 1;
    localparam int PA = P1 * 2;
    localparam int PB = P1 * 2 + 1;
    localparam int IA = ((U ^ P1) << 1) | U;
    localparam int IB = ((U ^ P1 ^ 1) << 1) | (U ^ 1);
    logic [PM_W-1:0] cand_a, cand_b;
    assign cand_a    = pm_adj[PA] + PM_W'(bm[IA]);
    assign cand_b    = pm_adj[PB] + PM_W'(bm[IB]);
    assign dec[ns]   = (cand_b < cand_a);
    assign pm_nx[ns] = dec[ns] ? cand_b : cand_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTATE; i++) pm[i] <= (i == 0) ? '0 : INIT_V;
    end else if (step_en) begin
      pm <= pm_nx;
    end
  end

  for (genvar i = 0; i < NSTATE; i++) begin : g_bound
    a_r10_pm_bounded: assert property (@(posedge clk) disable iff (rst)
      32'(pm[i]) < GUARD);
  end

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pm));
endmodule

// File: rtl/vit_tbu.sv
module vit_tbu
  import vit_pkg::*;
#(
  parameter int PM_W      = 8,
  parameter int MAX_DEPTH = 32,
  parameter int DEPTH_W   = 6
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step_en,
  input  logic [NSTATE-1:0]           dec_in,
  input  logic [NSTATE-1:0][PM_W-1:0] pm,
  input  logic [DEPTH_W-1:0]          depth,
  output logic                        bit_valid,
  output logic                        bit_out
);
  localparam logic [DEPTH_W-1:0] STEP_CAP = DEPTH_W'(MAX_DEPTH + 1);

  logic [NSTATE-1:0]  dec_mem [MAX_DEPTH];
  logic [DEPTH_W-1:0] steps;
  state_t             best;
  state_t             st [MAX_DEPTH+1];

  // Decision history, newest at index 0; no reset so it can map to plain storage.
  always_ff @(posedge clk) begin
    if (step_en) begin
      dec_mem[0] <= dec_in;
      for (int j = 1; j < MAX_DEPTH; j++) dec_mem[j] <= dec_mem[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      steps     <= '0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= step_en && (steps >= depth);
      if (step_en && (steps < STEP_CAP)) steps <= steps + 1'b1;
    end
  end

  always_comb begin
    best = '0;
    for (int i = 1; i < NSTATE; i++)
      if (pm[i] < pm[best]) best = state_t'(i);
  end

  assign st[0] = best;
  for (genvar j = 0; j < MAX_DEPTH; j++) begin : g_trace
    assign st[j+1] = {st[j][0], dec_mem[j][st[j]]};
  end
  assign bit_out = st[depth][ST_W-1];

  a_r7_enough_history: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (steps > depth));
endmodule

// File: rtl/vit_packer.sv
module vit_packer #(
  parameter int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] acc;
  logic [CNT_W-1:0]  fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (bit_valid) begin
        if (fill == LAST) begin
          out_byte  <= {acc, bit_in};
          out_valid <= 1'b1;
          fill      <= '0;
        end else begin
          acc  <= {acc[BYTE_W-3:0], bit_in};
          fill <= fill + 1'b1;
        end
      end
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r9_byte_from_bit: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(bit_valid));
endmodule

// File: rtl/vit_soft_decoder.sv
module vit_soft_decoder
  import vit_pkg::*;
#(
  parameter int PM_W      = 8,
  parameter int MIN_DEPTH = 8,
  parameter int MAX_DEPTH = 32,
  parameter int BYTE_W    = 8,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 2)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [SYM_W-1:0]   in_sym_a,
  input  logic [SYM_W-1:0]   in_sym_b,
  input  logic [DEPTH_W-1:0] tb_len,
  output logic               out_valid,
  output logic [BYTE_W-1:0]  out_byte
);
  localparam logic [DEPTH_W-1:0] DMIN = DEPTH_W'(MIN_DEPTH);
  localparam logic [DEPTH_W-1:0] DMAX = DEPTH_W'(MAX_DEPTH);

  logic                        v_q;
  soft_t                       a_q, b_q;
  logic [DEPTH_W-1:0]          depth_q;
  bm_t [NSTATE-1:0]            bm;
  logic [NSTATE-1:0][PM_W-1:0] pm;
  logic [NSTATE-1:0]           dec;
  logic                        tb_valid, tb_bit;

  // Input pipeline register
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= in_sym_a;
        b_q <= in_sym_b;
      end
    end
  end

  // Depth is captured while in reset only, clamped into range
  always_ff @(posedge clk) begin
    if (rst) begin
      if (tb_len < DMIN)      depth_q <= DMIN;
      else if (tb_len > DMAX) depth_q <= DMAX;
      else                    depth_q <= tb_len;
    end
  end

  vit_bmu u_bmu (
    .clk   (clk),
    .rst   (rst),
    .sym_a (a_q),
    .sym_b (b_q),
    .bm    (bm)
  );

  vit_acs #(.PM_W(PM_W)) u_acs (
    .clk     (clk),
    .rst     (rst),
    .step_en (v_q),
    .bm      (bm),
    .pm      (pm),
    .dec     (dec)
  );

  vit_tbu #(.PM_W(PM_W), .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_tbu (
    .clk       (clk),
    .rst       (rst),
    .step_en   (v_q),
    .dec_in    (dec),
    .pm        (pm),
    .depth     (depth_q),
    .bit_valid (tb_valid),
    .bit_out   (tb_bit)
  );

  vit_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (tb_valid),
    .bit_in    (tb_bit),
    .out_valid (out_valid),
    .out_byte  (out_byte)
  );

  a_r6_depth_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(depth_q));
  a_r5_depth_range: assert property (@(posedge clk) disable iff (rst)
    (depth_q >= DMIN) && (depth_q <= DMAX));
endmodule

// File: tb/vit_soft_decoder_bench.sv
module vit_soft_decoder_bench;
  localparam int CLK_P = 10;
  localparam int MAXN  = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] in_sym_a = '0, in_sym_b = '0;
  logic [5:0] tb_len = 6'd32;
  logic       out_valid;
  logic [7:0] out_byte;

  int total = 0, bad = 0, rx_n = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  bit         dbits [MAXN];
  logic [2:0] sa [MAXN], sb [MAXN];
  bit         c0 [MAXN], c1 [MAXN];
  logic [7:0] rx [256];

  always #(CLK_P/2) clk = ~clk;

  vit_soft_decoder u_vit_soft_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym_a(in_sym_a),
    .in_sym_b(in_sym_b), .tb_len(tb_len), .out_valid(out_valid), .out_byte(out_byte)
  );

  always @(negedge clk)
    if (!rst && out_valid) begin
      if (rx_n < 256) rx[rx_n] = out_byte;
      rx_n = rx_n + 1;
    end

  function automatic int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[23:8]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input int d);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; tb_len = 6'(d);
    repeat (3) @(negedge clk);
    rst = 1'b0; rx_n = 0;
  endtask

  // Encoder reference: state {s1,s0}, s1 newest; c0 = u^s1^s0 (gen 7), c1 = u^s0 (gen 5)
  task automatic make_stream(input int n);
    bit s1 = 0, s0 = 0;
    for (int i = 0; i < n; i++) begin
      dbits[i] = rnd() % 2 == 1;
      c0[i] = dbits[i] ^ s1 ^ s0;
      c1[i] = dbits[i] ^ s0;
      s0 = s1; s1 = dbits[i];
      sa[i] = {c0[i], 2'b11};
      sb[i] = {c1[i], 2'b11};
    end
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        int idle = rnd() % 4;
        for (int g = 0; g < idle; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_sym_a = 3'(rnd()); in_sym_b = 3'(rnd());
        end
      end
      @(negedge clk);
      in_valid = 1'b1; in_sym_a = sa[i]; in_sym_b = sb[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_bytes(input string req, input int n, input int d);
    int exp_n = (n - d) / 8;
    int wrong = 0, first = -1;
    logic [7:0] e, got_first = '0, exp_first = '0;
    chk(rx_n == exp_n, req, "byte count", rx_n, exp_n);
    for (int j = 0; j < exp_n && j < rx_n; j++) begin
      for (int k = 0; k < 8; k++) e[7-k] = dbits[8*j+k];
      if (rx[j] !== e) begin
        wrong++;
        if (first < 0) begin first = j; got_first = rx[j]; exp_first = e; end
      end
    end
    chk(wrong == 0, req, $sformatf("byte %0d value", first), int'(got_first), int'(exp_first));
  endtask

  // R11, R1: reset state and reset in mid-stream
  task automatic t_reset();
    do_reset(32);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_byte == 8'h00, "R11", "idle after reset", int'(out_byte), 0);
    end
    make_stream(120);
    for (int i = 0; i < 120; i++) begin sa[i] = {~c0[i], 2'b11}; end
    feed(120, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_byte == 8'h00, "R11", "outputs during reset", int'(out_byte), 0);
    do_reset(32);
    make_stream(96);
    feed(96, 1'b0);
    check_bytes("R11 fresh start", 96, 32);
  endtask

  task automatic t_clean(input int n, input int d);   // R1 R7 R9
    do_reset(d);
    make_stream(n);
    feed(n, 1'b0);
    check_bytes($sformatf("R1/R9 clean depth %0d", d), n, d);
  endtask

  task automatic t_latency();   // R7
    localparam int D = 20;
    do_reset(D);
    make_stream(D + 8);
    for (int i = 0; i < D + 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sym_a = sa[i]; in_sym_b = sb[i];
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      if (i == D + 6) chk(rx_n == 0, "R7", "no byte after D+7 steps", rx_n, 0);
    end
    check_bytes("R7 first byte at D+8", D + 8, D);
  endtask

  task automatic t_gaps();   // R8
    do_reset(16);
    make_stream(160);
    feed(160, 1'b1);
    check_bytes("R8 gaps ignored", 160, 16);
  endtask

  task automatic t_errors();   // R3
    do_reset(32);
    make_stream(300);
    for (int i = 12; i < 260; i += 37) begin
      if (i % 2 == 1) sa[i][2] = ~sa[i][2];
      else            sb[i][2] = ~sb[i][2];
    end
    feed(300, 1'b0);
    check_bytes("R3 strong errors", 300, 32);
  endtask

  task automatic t_erasure();   // R4
    do_reset(24);
    make_stream(200);
    for (int i = 5; i < 160; i += 25) begin
      sa[i] = {~c0[i], 2'b00};
      sb[i+3] = {~c1[i+3], 2'b00};
    end
    feed(200, 1'b0);
    check_bytes("R4 weak wrong symbols", 200, 24);
  endtask

  task automatic t_noise();   // R2 R10
    do_reset(24);
    make_stream(700);
    for (int i = 0; i < 700; i++) begin
      sa[i] = {c0[i], 2'(rnd())};
      sb[i] = {c1[i], 2'(rnd())};
    end
    feed(700, 1'b0);
    check_bytes("R2/R10 mixed magnitudes long", 700, 24);
  endtask

  task automatic t_depth_hold();   // R6
    do_reset(8);
    tb_len = 6'd32;
    make_stream(40);
    feed(40, 1'b0);
    check_bytes("R6 depth change ignored", 40, 8);
  endtask

  task automatic t_clamp();   // R5
    do_reset(3);
    make_stream(40);
    feed(40, 1'b0);
    check_bytes("R5 low clamp", 40, 8);
    do_reset(50);
    make_stream(48);
    feed(48, 1'b0);
    check_bytes("R5 high clamp", 48, 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean(200, 32);
    t_clean(120, 8);
    t_latency();
    t_gaps();
    t_errors();
    t_erasure();
    t_noise();
    t_depth_hold();
    t_clamp();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule